// File: doc/BRIEF.md
# Mixed-Sign Single-Cycle Multiplier

This block forms the 32-bit product of two 16-bit operands in a single clock cycle. Each operand carries its own signedness flag, so one datapath serves signed-by-signed, unsigned-by-unsigned and both mixed-sign cases. Before multiplying, each operand is widened by one bit: a signed operand copies its top bit into the new bit and an unsigned operand gets a zero there. The two 17-bit values are then multiplied as two's-complement numbers. The exact product of any two 16-bit operands, whatever their signedness, fits in the low 32 bits of that signed product, and those 32 bits are returned.

The caller presents the operands, the two flags and a strobe in one cycle. On the next clock edge the product register loads and the result-valid output rises for one cycle. A small two-state output sequencer drives the valid flag. State `OS_IDLE` means no fresh result; state `OS_FRESH` means the product register was loaded on the last edge. The transition `take` (strobe high) leads from either state to `OS_FRESH`. The transition `drop` (strobe low) leads from either state to `OS_IDLE`. Without a strobe, the product register keeps its last value.

Top module: `xsign_mul`

## Requirements
- R1: While reset is asserted and after its release with no strobe, `res_vld` is 0 and `res` is 0x0000_0000.
- R2: `res_vld` is 1 in exactly the cycle after a cycle with `in_vld` = 1, and 0 after a cycle with `in_vld` = 0.
- R3: With `a_sgn` = 0 and `b_sgn` = 0, both operands are read as unsigned values (0 to 65535), and `res` is their exact product.
- R4: With `a_sgn` = 1 and `b_sgn` = 1, both operands are read as two's-complement values (-32768 to 32767), and `res` is their exact product as a 32-bit two's-complement value. For example, 0x8000 x 0x8000 gives 0x4000_0000.
- R5: With exactly one flag set, the flagged operand is read as two's-complement and the other as unsigned, and `res` is the exact product as 32-bit two's-complement. For example, signed 0xFFFF times unsigned 0xFFFF gives 0xFFFF_0001.
- R6: In a cycle with `in_vld` = 0, the operand and flag inputs have no effect: `res` keeps its previous value on the next edge.
- R7: The latency is exactly one cycle. Back-to-back strobes give a new, correct product in every cycle, each computed from the inputs of the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operands valid strobe |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| a_sgn | input | 1 | 1: opa is two's-complement; 0: opa is unsigned |
| b_sgn | input | 1 | 1: opb is two's-complement; 0: opb is unsigned |
| res | output | 32 | Registered product |
| res_vld | output | 1 | High for one cycle when res holds a fresh product |

## Verification
The bound checker checks these properties on every cycle:
- `res_vld` follows the previous cycle's strobe.
- `res` holds its value across cycles without a strobe.
- `res` equals a behavioural product of the previous cycle's inputs, separately for each of the four flag combinations.
- Reset clears the valid flag.

Only the bench scenarios show the following:
- The value of `res` right after reset.
- The behaviour at the named operand extremes (0x0000, 0x7FFF, 0x8000 and 0xFFFF) in every signedness mix.
- That changing the operands while the strobe is low really leaves the output untouched.

// File: rtl/xsm_pkg.sv
package xsm_pkg;

    // Output sequencer states
    typedef enum logic {
        OS_IDLE  = 1'b0,
        OS_FRESH = 1'b1
    } out_state_e;

endpackage

// File: rtl/xsm_extend.sv
// Widens one operand by a single bit, either by sign or by zero.
module xsm_extend #(
    parameter int OPW = 16
) (
    input  logic [OPW-1:0] raw,
    input  logic           is_signed,
    output logic [OPW:0]   wide
);
    always_comb begin
        wide = {is_signed & raw[OPW-1], raw};
    end
endmodule

// File: rtl/xsm_array.sv
// Two's-complement shift-add array over EW-bit operands.
// Only the low OW bits of the product are formed; they are exact modulo 2**OW.
module xsm_array #(
    parameter int EW = 17,
    parameter int OW = 32
) (
    input  logic [EW-1:0] mcand,
    input  logic [EW-1:0] mplier,
    output logic [OW-1:0] prod
);
    logic [OW-1:0] mc_x;
    logic [OW-1:0] rows [EW];
    logic [OW-1:0] acc;

    // Sign-extend the multiplicand into the result width
    always_comb begin
        mc_x = {{(OW-EW){mcand[EW-1]}}, mcand};
    end

    genvar gi;
    generate
        for (gi = 0; gi < EW; gi++) begin : g_row
            if (gi < EW-1) begin : g_pos
                // Positive-weight multiplier bit
                always_comb rows[gi] = mplier[gi] ? (mc_x << gi) : '0;
            end else begin : g_neg
                // The top multiplier bit weighs -2**(EW-1)
                always_comb rows[gi] = mplier[gi] ? (~(mc_x << gi) + 1'b1) : '0;
            end
        end
    endgenerate

    always_comb begin
        acc = '0;
        for (int k = 0; k < EW; k++) begin
            acc = acc + rows[k];
        end
    end

    always_comb prod = acc;
endmodule

// File: rtl/xsm_outreg.sv
// Output stage: product register and a two-state valid sequencer.
module xsm_outreg
    import xsm_pkg::*;
#(
    parameter int OW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [OW-1:0] prod_in,
    output logic [OW-1:0] prod_q,
    output logic          fresh
);
    out_state_e st_q;
    out_state_e st_d;

    // Transitions: take -> OS_FRESH, drop -> OS_IDLE
    always_comb begin
        unique case (st_q)
            OS_IDLE:  st_d = take ? OS_FRESH : OS_IDLE;
            OS_FRESH: st_d = take ? OS_FRESH : OS_IDLE;
            default:  st_d = OS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= OS_IDLE;
        else        st_q <= st_d;
    end

    // Product register, loaded only on a strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    prod_q <= '0;
        else if (take) prod_q <= prod_in;
    end

    // Outputs
    always_comb begin
        unique case (st_q)
            OS_FRESH: fresh = 1'b1;
            default:  fresh = 1'b0;
        endcase
    end
endmodule

// File: rtl/xsign_mul.sv
module xsign_mul #(
    parameter int OPW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [OPW-1:0]   opa,
    input  logic [OPW-1:0]   opb,
    input  logic             a_sgn,
    input  logic             b_sgn,
    output logic [2*OPW-1:0] res,
    output logic             res_vld
);
    localparam int EW = OPW + 1;
    localparam int PW = 2 * OPW;

    logic [EW-1:0] a_w;
    logic [EW-1:0] b_w;
    logic [PW-1:0] p_comb;

    xsm_extend #(.OPW(OPW)) u_ext_a (.raw(opa), .is_signed(a_sgn), .wide(a_w));
    xsm_extend #(.OPW(OPW)) u_ext_b (.raw(opb), .is_signed(b_sgn), .wide(b_w));

    xsm_array #(.EW(EW), .OW(PW)) u_arr (
        .mcand (a_w),
        .mplier(b_w),
        .prod  (p_comb)
    );

    xsm_outreg #(.OW(PW)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (in_vld),
        .prod_in(p_comb),
        .prod_q (res),
        .fresh  (res_vld)
    );
endmodule

// File: rtl/xsm_checker.sv
module xsm_checker #(
    parameter int OPW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic [OPW-1:0]   opa,
    input logic [OPW-1:0]   opb,
    input logic             a_sgn,
    input logic             b_sgn,
    input logic [2*OPW-1:0] res,
    input logic             res_vld
);
    logic signed [OPW:0]     xa;
    logic signed [OPW:0]     xb;
    logic signed [2*OPW-1:0] beh;

    // Behavioural product via the language operator
    always_comb begin
        xa  = $signed({a_sgn & opa[OPW-1], opa});
        xb  = $signed({b_sgn & opb[OPW-1], opb});
        beh = xa * xb;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !res_vld);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> res_vld);

    a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !res_vld);

    a_r3_unsigned_prod: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !a_sgn && !b_sgn) |=> (res == $past(beh)));

    a_r4_signed_prod: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && a_sgn && b_sgn) |=> (res == $past(beh)));

    a_r5_mixed_prod: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (a_sgn != b_sgn)) |=> (res == $past(beh)));

    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(res));
endmodule

bind xsign_mul xsm_checker #(.OPW(OPW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (in_vld),
    .opa    (opa),
    .opb    (opb),
    .a_sgn  (a_sgn),
    .b_sgn  (b_sgn),
    .res    (res),
    .res_vld(res_vld)
);

// File: tb/sim_xsign_mul.sv
`timescale 1ns/1ps
module sim_xsign_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic        a_sgn = 1'b0;
    logic        b_sgn = 1'b0;
    logic [31:0] res;
    logic        res_vld;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    xsign_mul u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .opa(opa), .opb(opb), .a_sgn(a_sgn), .b_sgn(b_sgn),
        .res(res), .res_vld(res_vld)
    );

    // Expected product from the requirement wording
    function automatic logic [31:0] expect_prod(input logic [15:0] a, input logic [15:0] b,
                                                input logic sa, input logic sb);
        longint va;
        longint vb;
        longint p;
        va = sa ? longint'($signed(a)) : longint'(a);
        vb = sb ? longint'($signed(b)) : longint'(b);
        p  = va * vb;
        return p[31:0];
    endfunction

    function automatic string req_of(input logic sa, input logic sb);
        if (!sa && !sb) return "R3";
        if (sa && sb)   return "R4";
        return "R5";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one strobed operation at negedge, check at the following negedge
    task automatic one_op(input logic [15:0] a, input logic [15:0] b,
                          input logic sa, input logic sb);
        @(negedge clk);
        opa = a; opb = b; a_sgn = sa; b_sgn = sb; in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        check(req_of(sa, sb), res, expect_prod(a, b, sa, sb));
        check("R2", {31'b0, res_vld}, 32'd1);
    endtask

    initial begin
        logic [15:0] corner [4];
        logic [31:0] held;
        corner[0] = 16'h0000; corner[1] = 16'h7FFF;
        corner[2] = 16'h8000; corner[3] = 16'hFFFF;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", res, 32'h0);
        check("R1", {31'b0, res_vld}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1", res, 32'h0);
        check("R1", {31'b0, res_vld}, 32'd0);

        // Named examples from R4 and R5
        one_op(16'h8000, 16'h8000, 1'b1, 1'b1);
        check("R4", res, 32'h4000_0000);
        one_op(16'hFFFF, 16'hFFFF, 1'b1, 1'b0);
        check("R5", res, 32'hFFFF_0001);

        // Corner operands in all four signedness combinations
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 4; i++) begin
                for (int j = 0; j < 4; j++) begin
                    one_op(corner[i], corner[j], m[1], m[0]);
                end
            end
        end

        // R6: inputs ignored without strobe; R2 valid low
        one_op(16'h1234, 16'h5678, 1'b0, 1'b0);
        held = res;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            opa = 16'($urandom); opb = 16'($urandom);
            a_sgn = 1'($urandom); b_sgn = 1'($urandom);
            in_vld = 1'b0;
            @(negedge clk);
            check("R6", res, held);
            check("R2", {31'b0, res_vld}, 32'd0);
        end

        // R7: back-to-back strobes, random operands and flags
        @(negedge clk);
        begin
            logic [15:0] pa;
            logic [15:0] pb;
            logic        psa;
            logic        psb;
            pa = 16'($urandom); pb = 16'($urandom);
            psa = 1'($urandom); psb = 1'($urandom);
            opa = pa; opb = pb; a_sgn = psa; b_sgn = psb; in_vld = 1'b1;
            for (int k = 0; k < 300; k++) begin
                @(negedge clk);
                check("R7", res, expect_prod(pa, pb, psa, psb));
                check("R7", {31'b0, res_vld}, 32'd1);
                pa = 16'($urandom); pb = 16'($urandom);
                psa = 1'($urandom); psb = 1'($urandom);
                opa = pa; opb = pb; a_sgn = psa; b_sgn = psb;
            end
            in_vld = 1'b0;
        end

        // Random isolated operations with gaps
        for (int k = 0; k < 200; k++) begin
            one_op(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));
            if (($urandom % 3) == 0) @(negedge clk);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule